// File: doc/BRIEF.md
# Zone Display List Fetch Sequencer

This block reads one zone's display list out of memory and turns it into a stream of graphics fetches. A start pulse supplies the base address of the list. The block then reads entry headers one byte at a time over a byte-wide read port. Each entry describes a run of graphics bytes. The run is either fetched directly from a pointer, or fetched through a character map whose bytes select glyphs in a page given by a high-byte input. For every graphics byte it fetches, the block presents one record on its output: the data, its horizontal position, the palette, the write-mode bit and the double-width bit. A later pixel stage consumes these records.

Graphics for the line being built sit one 256-byte page per line above the entry's pointer, which points at the object's bottom line. Optionally, an entry whose line address lands in an empty region is skipped outright, so the unused rows above and below an object need no stored bytes. The list ends at a zero second byte. A done pulse follows.

Top module: `dl_parser`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_req_o` and `rec_valid_o` are all low, and they stay low until `start_i` is pulsed.
- R2: Header byte 1 decides the entry length. If its bits [4:0] are nonzero, the entry is 4 bytes: {ptr_lo, {pal[7:5],cnt[4:0]}, ptr_hi, hpos}, direct, with write mode 0. If it is nonzero and its bits [4:0] are zero, the entry is 5 bytes: {ptr_lo, {wm[7],ind[6],1[5],0[4:0]}, ptr_hi, {pal,cnt}, hpos}. The next entry follows directly after the current one.
- R3: An entry whose header byte 1 is zero ends the list. Only its two bytes are read, `busy_o` drops and `done_o` pulses high for exactly one cycle.
- R4: For a direct entry and line offset L = `line_i`, byte k (0 ≤ k < cnt) is read from address ptr + L·256 + k, using 16-bit wrap. It is emitted in order as one record.
- R5: The first record of an entry carries the entry's hpos. Each later record adds 4 (wm=0) or 2 (wm=1), modulo 256.
- R6: Each record carries the entry's pal and wm. 4-byte entries always give wm=0.
- R7: For an indirect entry with `char_wide_i`=0, character k is read from ptr + k. That byte c then gives one graphics read at {`charbase_i`, c} + L·256, with `rec_wide_o`=0.
- R8: For an indirect entry with `char_wide_i`=1, each character gives two records, read from G and G+1 where G = {`charbase_i`, c} + L·256. The carry crosses the page. Both records have `rec_wide_o`=1.
- R9: With `hole_en_i`=1, a direct entry whose ptr + L·256 has bit 8+LINE_BITS set (bit 12 by default) reads no graphics and emits no records. Parsing then moves on to the next entry. Indirect entries are never skipped.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running list completes unchanged.
- R11: An entry with cnt = 0 emits no record and reads no graphics.
- R12: The read port has one request outstanding at a time. Data is taken on `mem_rdata_i` one cycle after `mem_req_o`, and `mem_req_o` is never high in two consecutive cycles or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin parsing a list (ignored while busy) |
| list_base_i | input | 16 | Address of the first entry |
| line_i | input | LINE_BITS | Line offset within the zone |
| charbase_i | input | 8 | High address byte for character graphics |
| char_wide_i | input | 1 | Two graphics bytes per character |
| hole_en_i | input | 1 | Enable skipping of empty-region entries |
| busy_o | output | 1 | Parse in progress |
| done_o | output | 1 | One-cycle pulse after the terminator |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a request |
| rec_valid_o | output | 1 | Record valid |
| rec_data_o | output | 8 | Graphics byte |
| rec_hpos_o | output | 8 | Horizontal position |
| rec_pal_o | output | 3 | Palette |
| rec_wm_o | output | 1 | Write mode |
| rec_wide_o | output | 1 | Double-width character fetch |

## Verification
The assertions assume `start_i` is a single-cycle pulse. They also assume memory answers every request with data in the very next cycle, and that each list in memory reaches a terminator. The bench's memory model always responds one cycle after a request. Every list the bench builds ends in a zero header byte. The configuration inputs are only changed while the block is idle, and the second start pulse in the restart test arrives while a run is in progress.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int AW    = 16;
  localparam int CNT_W = 5;
  localparam int PAL_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_EVAL,
    ST_CMAP,
    ST_GFX
  } st_e;

  typedef struct packed {
    logic             ext;
    logic [AW-1:0]    ptr;
    logic [PAL_W-1:0] pal;
    logic [CNT_W-1:0] cnt;
    logic             wm;
    logic             ind;
    logic [7:0]       hpos;
  } dec_t;
endpackage

// File: rtl/dl_hdr_decode.sv
module dl_hdr_decode
  import dl_pkg::*;
(
  input  logic [4:0][7:0] hdr_i,
  output dec_t            dec_o
);
  logic       ext;
  logic [7:0] pc_byte;
  logic       unused_marker;

  assign ext           = (hdr_i[1][4:0] == 5'd0);
  assign pc_byte       = ext ? hdr_i[3] : hdr_i[1];
  assign unused_marker = hdr_i[1][5];

  always_comb begin
    dec_o.ext  = ext;
    dec_o.ptr  = {hdr_i[2], hdr_i[0]};
    dec_o.pal  = pc_byte[7:5];
    dec_o.cnt  = pc_byte[4:0];
    dec_o.wm   = ext & hdr_i[1][7];
    dec_o.ind  = ext & hdr_i[1][6];
    dec_o.hpos = ext ? hdr_i[4] : hdr_i[3];
  end
endmodule

// File: rtl/dl_addr_gen.sv
module dl_addr_gen
  import dl_pkg::*;
#(
  parameter int LINE_BITS = 4
) (
  input  st_e                  st_i,
  input  logic [AW-1:0]        cur_i,
  input  logic [2:0]           hb_i,
  input  logic [AW-1:0]        ptr_i,
  input  logic [CNT_W-1:0]     k_i,
  input  logic [LINE_BITS-1:0] line_i,
  input  logic [7:0]           cbase_i,
  input  logic [7:0]           chr_i,
  input  logic                 sub_i,
  input  logic                 ind_i,
  input  logic                 hole_en_i,
  output logic [AW-1:0]        addr_o,
  output logic                 hole_o
);
  localparam int HOLE_BIT = 8 + LINE_BITS;

  logic [AW-1:0] line_ofs;
  logic [AW-1:0] line_base;
  logic [AW-1:0] chr_base;

  assign line_ofs  = AW'(line_i) << 8;
  assign line_base = ptr_i + line_ofs;
  assign chr_base  = {cbase_i, chr_i} + line_ofs;

  generate
    if (HOLE_BIT < AW) begin : g_hole
      assign hole_o = hole_en_i & line_base[HOLE_BIT];
    end else begin : g_no_hole
      logic unused_hole;
      assign unused_hole = hole_en_i;
      assign hole_o      = 1'b0;
    end
  endgenerate

  always_comb begin
    case (st_i)
      ST_HDR:  addr_o = cur_i + AW'(hb_i);
      ST_CMAP: addr_o = ptr_i + AW'(k_i);
      ST_GFX:  addr_o = ind_i ? (chr_base + AW'(sub_i)) : (line_base + AW'(k_i));
      default: addr_o = cur_i;
    endcase
  end
endmodule

// File: rtl/dl_parser.sv
module dl_parser
  import dl_pkg::*;
#(
  parameter int LINE_BITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [15:0]          list_base_i,
  input  logic [LINE_BITS-1:0] line_i,
  input  logic [7:0]           charbase_i,
  input  logic                 char_wide_i,
  input  logic                 hole_en_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 mem_req_o,
  output logic [15:0]          mem_addr_o,
  input  logic [7:0]           mem_rdata_i,
  output logic                 rec_valid_o,
  output logic [7:0]           rec_data_o,
  output logic [7:0]           rec_hpos_o,
  output logic [2:0]           rec_pal_o,
  output logic                 rec_wm_o,
  output logic                 rec_wide_o
);
  st_e                  state_q;
  logic                 pend_q;
  logic [AW-1:0]        cur_q;
  logic [2:0]           hb_q;
  logic [4:0][7:0]      hdr_q;
  logic [LINE_BITS-1:0] line_q;
  logic [7:0]           cbase_q;
  logic                 cwide_q;
  logic                 hen_q;
  logic [CNT_W-1:0]     k_q;
  logic                 sub_q;
  logic [7:0]           chr_q;
  logic [7:0]           hpos_q;
  logic                 done_q;
  logic                 rv_q;
  logic [7:0]           rd_q;
  logic [7:0]           rh_q;
  logic [PAL_W-1:0]     rp_q;
  logic                 rw_q;
  logic                 rx_q;

  dec_t       dec;
  logic       hole;
  logic       req;
  logic [2:0] ent_len;
  logic       two_byte;

  dl_hdr_decode u_dec (
    .hdr_i (hdr_q),
    .dec_o (dec)
  );

  dl_addr_gen #(.LINE_BITS(LINE_BITS)) u_addr (
    .st_i      (state_q),
    .cur_i     (cur_q),
    .hb_i      (hb_q),
    .ptr_i     (dec.ptr),
    .k_i       (k_q),
    .line_i    (line_q),
    .cbase_i   (cbase_q),
    .chr_i     (chr_q),
    .sub_i     (sub_q),
    .ind_i     (dec.ind),
    .hole_en_i (hen_q),
    .addr_o    (mem_addr_o),
    .hole_o    (hole)
  );

  assign ent_len  = dec.ext ? 3'd5 : 3'd4;
  assign two_byte = dec.ind & cwide_q;
  assign req      = !pend_q && (state_q == ST_HDR || state_q == ST_CMAP || state_q == ST_GFX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      cur_q   <= '0;
      hb_q    <= '0;
      hdr_q   <= '0;
      line_q  <= '0;
      cbase_q <= '0;
      cwide_q <= 1'b0;
      hen_q   <= 1'b0;
      k_q     <= '0;
      sub_q   <= 1'b0;
      chr_q   <= '0;
      hpos_q  <= '0;
      done_q  <= 1'b0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
      rh_q    <= '0;
      rp_q    <= '0;
      rw_q    <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      pend_q <= req;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cur_q   <= list_base_i;
            line_q  <= line_i;
            cbase_q <= charbase_i;
            cwide_q <= char_wide_i;
            hen_q   <= hole_en_i;
            hb_q    <= '0;
            state_q <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (pend_q) begin
            hdr_q[hb_q] <= mem_rdata_i;
            if (hb_q == 3'd1 && mem_rdata_i == 8'h00) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (hb_q == ent_len - 3'd1) begin
              state_q <= ST_EVAL;
            end else begin
              hb_q <= hb_q + 3'd1;
            end
          end
        end
        ST_EVAL: begin
          cur_q  <= cur_q + AW'(ent_len);
          hb_q   <= '0;
          k_q    <= '0;
          sub_q  <= 1'b0;
          hpos_q <= dec.hpos;
          if (dec.cnt == '0 || (!dec.ind && hole)) state_q <= ST_HDR;
          else state_q <= dec.ind ? ST_CMAP : ST_GFX;
        end
        ST_CMAP: begin
          if (pend_q) begin
            chr_q   <= mem_rdata_i;
            state_q <= ST_GFX;
          end
        end
        ST_GFX: begin
          if (pend_q) begin
            rv_q   <= 1'b1;
            rd_q   <= mem_rdata_i;
            rh_q   <= hpos_q;
            rp_q   <= dec.pal;
            rw_q   <= dec.wm;
            rx_q   <= two_byte;
            hpos_q <= hpos_q + (dec.wm ? 8'd2 : 8'd4);
            if (two_byte && !sub_q) begin
              sub_q <= 1'b1;
            end else begin
              sub_q <= 1'b0;
              k_q   <= k_q + 1'b1;
              if (k_q == dec.cnt - 1'b1) state_q <= ST_HDR;
              else if (dec.ind)          state_q <= ST_CMAP;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign mem_req_o   = req;
  assign rec_valid_o = rv_q;
  assign rec_data_o  = rd_q;
  assign rec_hpos_o  = rh_q;
  assign rec_pal_o   = rp_q;
  assign rec_wm_o    = rw_q;
  assign rec_wide_o  = rx_q;
endmodule

// File: rtl/dl_parser_chk.sv
module dl_parser_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic mem_req_o,
  input logic rec_valid_o
);
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R12
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R12
  AST_REC_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> busy_o); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o)); // R10
endmodule

bind dl_parser dl_parser_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .rec_valid_o (rec_valid_o)
);

// File: tb/sim_dl_parser.sv
module sim_dl_parser;
  localparam int LB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [15:0]   base;
  logic [LB-1:0] line;
  logic [7:0]    cbase;
  logic          cwide;
  logic          hen;
  logic          busy, done, req;
  logic [15:0]   addr;
  logic [7:0]    rdata;
  logic          rv, rwm, rwide;
  logic [7:0]    rdat, rhpos;
  logic [2:0]    rpal;

  always #10 clk = ~clk;

  dl_parser #(.LINE_BITS(LB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .list_base_i(base),
    .line_i(line), .charbase_i(cbase), .char_wide_i(cwide), .hole_en_i(hen),
    .busy_o(busy), .done_o(done), .mem_req_o(req), .mem_addr_o(addr),
    .mem_rdata_i(rdata), .rec_valid_o(rv), .rec_data_o(rdat),
    .rec_hpos_o(rhpos), .rec_pal_o(rpal), .rec_wm_o(rwm), .rec_wide_o(rwide)
  );

  typedef struct packed {
    logic [7:0] d;
    logic [7:0] h;
    logic [2:0] p;
    logic       w;
    logic       x;
  } rec_t;

  logic [7:0] ovr [int];
  rec_t got[$];
  rec_t exp_q[$];
  int n_req;
  logic [15:0] last_addr;
  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    if (ovr.exists(int'(a))) return ovr[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (req) begin
      rdata     <= pat(addr);
      n_req     <= n_req + 1;
      last_addr <= addr;
    end
  end

  always @(negedge clk) if (rv) got.push_back('{rdat, rhpos, rpal, rwm, rwide});

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic cmp(input string tag);
    chk(got.size() == exp_q.size(), tag, "record count", got.size(), exp_q.size());
    for (int i = 0; i < got.size() && i < exp_q.size(); i++)
      chk(got[i] == exp_q[i], tag, $sformatf("record %0d", i), longint'(got[i]), longint'(exp_q[i]));
  endtask

  task automatic ent4(input logic [15:0] a, input logic [15:0] p, input logic [2:0] pal,
                      input logic [4:0] cnt, input logic [7:0] hp);
    ovr[int'(a)] = p[7:0]; ovr[int'(a + 1)] = {pal, cnt};
    ovr[int'(a + 2)] = p[15:8]; ovr[int'(a + 3)] = hp;
  endtask

  task automatic ent5(input logic [15:0] a, input logic [15:0] p, input logic wm, input logic ind,
                      input logic [2:0] pal, input logic [4:0] cnt, input logic [7:0] hp);
    ovr[int'(a)] = p[7:0]; ovr[int'(a + 1)] = {wm, ind, 1'b1, 5'd0};
    ovr[int'(a + 2)] = p[15:8]; ovr[int'(a + 3)] = {pal, cnt}; ovr[int'(a + 4)] = hp;
  endtask

  task automatic term(input logic [15:0] a);
    ovr[int'(a)] = 8'h11; ovr[int'(a + 1)] = 8'h00;
  endtask

  task automatic exp_direct(input logic [15:0] p, input int ln, input int cnt, input logic [7:0] hp,
                            input logic [2:0] pal, input logic wm);
    logic [7:0] h = hp;
    for (int k = 0; k < cnt; k++) begin
      logic [15:0] a = p + 16'(ln) * 16'd256 + 16'(k);
      exp_q.push_back('{pat(a), h, pal, wm, 1'b0});
      h = h + (wm ? 8'd2 : 8'd4);
    end
  endtask

  task automatic exp_ind(input logic [15:0] p, input int ln, input int cnt, input logic [7:0] hp,
                         input logic [2:0] pal, input logic wm, input logic [7:0] cb, input logic wide);
    logic [7:0] h = hp;
    for (int k = 0; k < cnt; k++) begin
      logic [7:0]  c = pat(p + 16'(k));
      logic [15:0] g = {cb, c} + 16'(ln) * 16'd256;
      exp_q.push_back('{pat(g), h, pal, wm, wide});
      h = h + (wm ? 8'd2 : 8'd4);
      if (wide) begin
        exp_q.push_back('{pat(g + 16'd1), h, pal, wm, wide});
        h = h + (wm ? 8'd2 : 8'd4);
      end
    end
  endtask

  task automatic prep;
    ovr.delete(); exp_q.delete();
  endtask

  task automatic run(input string tag, input logic [15:0] b, input int ln, input logic [7:0] cb,
                     input logic cw, input logic he, input int re_at, input logic [15:0] re_base);
    bit seen = 0;
    @(negedge clk);
    got.delete(); n_req = 0;
    base = b; line = LB'(ln); cbase = cb; cwide = cw; hen = he; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      if (re_at != 0 && i == re_at) begin base = re_base; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      if (done) seen = 1;
    end
    start = 1'b0;
    chk(seen, tag, "done pulse seen", seen, 1);
    chk(!busy, tag, "idle with done", busy, 0);
    @(negedge clk);
    chk(!done, tag, "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!done, "R1", "done after reset", done, 0);
    chk(!req,  "R1", "req after reset", req, 0);
    chk(!rv,   "R1", "rec_valid after reset", rv, 0);
  endtask

  task automatic t_direct;
    prep();
    ent4(16'h0100, 16'h2010, 3'd5, 5'd3, 8'hFC);
    term(16'h0104);
    exp_direct(16'h2010, 3, 3, 8'hFC, 3'd5, 1'b0);
    run("R4", 16'h0100, 3, 8'h00, 1'b0, 1'b0, 0, 16'h0);
    cmp("R4");
    chk(got.size() == 3 && got[1].h == 8'h00 && got[2].h == 8'h04, "R5", "hpos wrap", got.size() > 1 ? got[1].h : 0, 0);
    chk(n_req == 9, "R3", "reads incl 2-byte terminator", n_req, 9);
    chk(last_addr == 16'h0105, "R3", "last read address", last_addr, 16'h0105);
  endtask

  task automatic t_chain;
    prep();
    ent5(16'h0100, 16'h4020, 1'b1, 1'b0, 3'd2, 5'd2, 8'h10);
    ent4(16'h0105, 16'h4100, 3'd7, 5'd1, 8'h80);
    term(16'h0109);
    exp_direct(16'h4020, 0, 2, 8'h10, 3'd2, 1'b1);
    exp_direct(16'h4100, 0, 1, 8'h80, 3'd7, 1'b0);
    run("R2", 16'h0100, 0, 8'h00, 1'b0, 1'b0, 0, 16'h0);
    cmp("R2");
    chk(got.size() == 3 && got[0].w && !got[2].w && got[2].p == 3'd7, "R6", "wm/pal per entry",
        got.size(), 3);
    chk(n_req == 14, "R2", "read count", n_req, 14);
  endtask

  task automatic t_ind;
    prep();
    ent5(16'h0100, 16'h0500, 1'b0, 1'b1, 3'd3, 5'd3, 8'h20);
    ovr[32'h0500] = 8'h07; ovr[32'h0501] = 8'h09; ovr[32'h0502] = 8'hF0;
    term(16'h0105);
    exp_ind(16'h0500, 2, 3, 8'h20, 3'd3, 1'b0, 8'h30, 1'b0);
    run("R7", 16'h0100, 2, 8'h30, 1'b0, 1'b0, 0, 16'h0);
    cmp("R7");
  endtask

  task automatic t_wide;
    prep();
    ent5(16'h0100, 16'h0500, 1'b1, 1'b1, 3'd6, 5'd2, 8'hF8);
    ovr[32'h0500] = 8'h40; ovr[32'h0501] = 8'hFF;
    term(16'h0105);
    exp_ind(16'h0500, 3, 2, 8'hF8, 3'd6, 1'b1, 8'h30, 1'b1);
    run("R8", 16'h0100, 3, 8'h30, 1'b1, 1'b0, 0, 16'h0);
    cmp("R8");
    chk(got.size() == 4 && got[3].d == pat(16'h3400), "R8", "page carry byte",
        got.size() == 4 ? got[3].d : 0, pat(16'h3400));
  endtask

  task automatic t_hole;
    prep();
    ent4(16'h0100, 16'h0F80, 3'd1, 5'd2, 8'h00);
    ent4(16'h0104, 16'h2000, 3'd4, 5'd2, 8'h40);
    term(16'h0108);
    exp_direct(16'h2000, 1, 2, 8'h40, 3'd4, 1'b0);
    run("R9", 16'h0100, 1, 8'h00, 1'b0, 1'b1, 0, 16'h0);
    cmp("R9");
    chk(n_req == 12, "R9", "no graphics reads when skipped", n_req, 12);
    exp_q.delete();
    exp_direct(16'h0F80, 1, 2, 8'h00, 3'd1, 1'b0);
    exp_direct(16'h2000, 1, 2, 8'h40, 3'd4, 1'b0);
    run("R9", 16'h0100, 1, 8'h00, 1'b0, 1'b0, 0, 16'h0);
    cmp("R9");
  endtask

  task automatic t_zero;
    prep();
    ent5(16'h0100, 16'h2000, 1'b0, 1'b0, 3'd1, 5'd0, 8'h00);
    ent4(16'h0105, 16'h2200, 3'd6, 5'd1, 8'h08);
    term(16'h0109);
    exp_direct(16'h2200, 0, 1, 8'h08, 3'd6, 1'b0);
    run("R11", 16'h0100, 0, 8'h00, 1'b0, 1'b0, 0, 16'h0);
    cmp("R11");
    chk(n_req == 12, "R11", "read count", n_req, 12);
  endtask

  task automatic t_restart;
    prep();
    ent4(16'h0100, 16'h2300, 3'd2, 5'd4, 8'h00);
    term(16'h0104);
    ent4(16'h0800, 16'h4400, 3'd3, 5'd1, 8'h00);
    term(16'h0804);
    exp_direct(16'h2300, 0, 4, 8'h00, 3'd2, 1'b0);
    run("R10", 16'h0100, 0, 8'h00, 1'b0, 1'b0, 5, 16'h0800);
    cmp("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; base = '0; line = '0; cbase = '0; cwide = 1'b0; hen = 1'b0;
    n_req = 0; last_addr = '0; rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_direct();
    t_chain();
    t_ind();
    t_wide();
    t_hole();
    t_zero();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule